// File: doc/BRIEF.md
# LCD Common Row Scan Timer

This block paces the row scan of a multiplexed dot-matrix liquid-crystal panel. Software-held settings for line count and character height pick how many common electrodes are driven: 8, 11 or 16. The block counts oscillator clocks within each row and walks a one-hot select across the common lines. At the start of each row it pulses a strobe so that the segment side can latch the next column pattern. At the start of each frame it pulses a second marker.

The block also produces the liquid-crystal polarity signal. This signal flips the drive so the cell never sees a net DC level. A static option pin chooses between two schemes. In the first, polarity flips in the middle of every row. In the second, it stays fixed for a whole frame and flips from one frame to the next. A bias-select output tells the analog divider whether to use the fifth-step or the quarter-step ladder.

A new setting is held off until the frame in progress has finished, so a row is never cut short. All outputs are registered.

Top module: `lcd_com_scan`

## Requirements
- R1: The active row count is 16 when `two_line_i` is 1, whatever the font. It is 11 when `two_line_i` is 0 and `tall_font_i` is 1. It is 8 when both are 0.
- R2: `bias_fifth_o` is 1 (fifth-step ladder) during a frame that scans 16 rows, and 0 during an 8-row or 11-row frame.
- R3: Each row lasts `ROW_LONG` clocks when 8 or 11 rows are active, and `ROW_SHORT` clocks when 16 rows are active.
- R4: `com_o` is one-hot, with bit k set during row k. Rows run upward from 0 and wrap to 0 after the last active row. Bits at or above the active row count stay 0.
- R5: `row_strobe_o` is high for exactly the first clock of every row and low otherwise.
- R6: `frame_start_o` is high only together with the row-0 strobe. Frames repeat every (row count × row length) clocks.
- R7: With `wave_b_i` = 0, `polarity_o` is 0 for the first floor(L/2) clocks of each row of length L and 1 for the rest of that row.
- R8: With `wave_b_i` = 1, `polarity_o` holds one value for a whole frame and alternates from frame to frame. The first frame after reset is 0.
- R9: A change of `two_line_i` or `tall_font_i` in mid-frame changes neither the row count, nor the row length, nor the bias until the next frame start.
- R10: While `rst` is high, all outputs are 0. The first clock edge after `rst` falls starts row 0 with both the row strobe and the frame-start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| two_line_i | input | 1 | 1 selects dual-line (16-row) scanning |
| tall_font_i | input | 1 | 1 selects the tall font in single-line mode (11 rows) |
| wave_b_i | input | 1 | Polarity scheme: 0 inverts per row half, 1 inverts per frame |
| com_o | output | NUM_COM | One-hot common line select |
| row_strobe_o | output | 1 | One-clock pulse at the start of each row |
| frame_start_o | output | 1 | One-clock pulse at the start of row 0 |
| polarity_o | output | 1 | Liquid-crystal drive polarity |
| bias_fifth_o | output | 1 | 1 = fifth-step bias, 0 = quarter-step bias |

## Verification
The bench runs all eight combinations of the line, font and waveform inputs, each for more than two full frames. Every output is compared on every clock against a position computed arithmetically from the time since reset. The line/font combinations distinguish the three row counts, including the case where dual-line mode must override the tall font. The two waveform settings separate in-row inversion from frame-parity inversion. A further run switches from 8 rows to 16 rows in mid-frame. That run shows whether the old row length and row count persist up to the frame boundary and whether the new ones start exactly there.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Row count selected by the line/font settings; dual-line overrides the font.
  function automatic int unsigned rows_for(input logic two_line,
                                           input logic tall_font,
                                           input int unsigned rows_dual,
                                           input int unsigned rows_tall,
                                           input int unsigned rows_short);
    if (two_line) return rows_dual;
    else if (tall_font) return rows_tall;
    else return rows_short;
  endfunction

  typedef enum logic {WAVE_ROW_SPLIT = 1'b0, WAVE_FRAME_FLIP = 1'b1} wave_kind_e;

endpackage

// File: rtl/lcd_duty_latch.sv
module lcd_duty_latch #(
  parameter int unsigned NUM_COM    = 16,
  parameter int unsigned ROWS_TALL  = 11,
  parameter int unsigned ROWS_SHORT = 8,
  localparam int unsigned ROW_W     = $clog2(NUM_COM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             two_line,
  input  logic             tall_font,
  output logic [ROW_W-1:0] rows_sel,
  output logic [ROW_W-1:0] rows_q
);
  import lcd_scan_pkg::*;

  always_comb begin
    rows_sel = ROW_W'(rows_for(two_line, tall_font, NUM_COM, ROWS_TALL, ROWS_SHORT));
  end

  always_ff @(posedge clk) begin
    if (rst || load) rows_q <= rows_sel;
  end
endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer #(
  parameter int unsigned NUM_COM   = 16,
  parameter int unsigned ROW_LONG  = 800,
  parameter int unsigned ROW_SHORT = 400,
  localparam int unsigned ROW_W    = $clog2(NUM_COM + 1),
  localparam int unsigned CNT_W    = $clog2(ROW_LONG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] rows_q,
  output logic             frame_go,
  output logic             row_go,
  output logic [CNT_W-1:0] cnt_d,
  output logic [ROW_W-1:0] row_d,
  output logic [CNT_W-1:0] half_len
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] len;
  logic             row_end;

  always_comb begin
    len      = (rows_q == ROW_W'(NUM_COM)) ? CNT_W'(ROW_SHORT) : CNT_W'(ROW_LONG);
    half_len = len >> 1;
    row_end  = (cnt_q == len - CNT_W'(1));
    frame_go = !run_q || (row_end && (row_q == rows_q - ROW_W'(1)));
    row_go   = frame_go || row_end;
    cnt_d    = row_go ? '0 : cnt_q + CNT_W'(1);
    if (frame_go)    row_d = '0;
    else if (row_go) row_d = row_q + ROW_W'(1);
    else             row_d = row_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      run_q <= 1'b1;
      cnt_q <= cnt_d;
      row_q <= row_d;
    end
  end
endmodule

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wave_b,
  input  logic             frame_go,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] half_len,
  output logic             polarity_q
);
  import lcd_scan_pkg::*;

  logic parity_q;
  logic parity_d;
  wave_kind_e kind;

  always_comb begin
    kind     = wave_kind_e'(wave_b);
    parity_d = frame_go ? ~parity_q : parity_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parity_q   <= 1'b1;
      polarity_q <= 1'b0;
    end else begin
      parity_q <= parity_d;
      if (kind == WAVE_FRAME_FLIP) polarity_q <= parity_d;
      else                         polarity_q <= (cnt_d >= half_len);
    end
  end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
  parameter int unsigned NUM_COM    = 16,
  parameter int unsigned ROWS_TALL  = 11,
  parameter int unsigned ROWS_SHORT = 8,
  parameter int unsigned ROW_LONG   = 800,
  parameter int unsigned ROW_SHORT  = 400
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               two_line_i,
  input  logic               tall_font_i,
  input  logic               wave_b_i,
  output logic [NUM_COM-1:0] com_o,
  output logic               row_strobe_o,
  output logic               frame_start_o,
  output logic               polarity_o,
  output logic               bias_fifth_o
);
  localparam int unsigned ROW_W = $clog2(NUM_COM + 1);
  localparam int unsigned CNT_W = $clog2(ROW_LONG + 1);

  logic [ROW_W-1:0] rows_sel, rows_q;
  logic             frame_go, row_go;
  logic [CNT_W-1:0] cnt_d, half_len;
  logic [ROW_W-1:0] row_d;
  logic [NUM_COM-1:0] com_d;

  lcd_duty_latch #(
    .NUM_COM(NUM_COM), .ROWS_TALL(ROWS_TALL), .ROWS_SHORT(ROWS_SHORT)
  ) u_duty (
    .clk(clk), .rst(rst), .load(frame_go),
    .two_line(two_line_i), .tall_font(tall_font_i),
    .rows_sel(rows_sel), .rows_q(rows_q)
  );

  lcd_row_timer #(
    .NUM_COM(NUM_COM), .ROW_LONG(ROW_LONG), .ROW_SHORT(ROW_SHORT)
  ) u_timer (
    .clk(clk), .rst(rst), .rows_q(rows_q),
    .frame_go(frame_go), .row_go(row_go),
    .cnt_d(cnt_d), .row_d(row_d), .half_len(half_len)
  );

  lcd_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .wave_b(wave_b_i), .frame_go(frame_go),
    .cnt_d(cnt_d), .half_len(half_len), .polarity_q(polarity_o)
  );

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    assign com_d[k] = (row_d == ROW_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_o         <= '0;
      row_strobe_o  <= 1'b0;
      frame_start_o <= 1'b0;
      bias_fifth_o  <= 1'b0;
    end else begin
      com_o         <= com_d;
      row_strobe_o  <= row_go;
      frame_start_o <= frame_go;
      if (frame_go) bias_fifth_o <= (rows_sel == ROW_W'(NUM_COM));
    end
  end
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
  parameter int unsigned NUM_COM   = 16,
  parameter int unsigned ROWS_TALL = 11
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_COM-1:0] com_o,
  input logic               row_strobe_o,
  input logic               frame_start_o,
  input logic               bias_fifth_o
);
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(com_o) == 1));

  a_r6_frame_on_row0: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (row_strobe_o && com_o[0]));

  a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
    (row_strobe_o && !frame_start_o) |-> (com_o == ($past(com_o) << 1)));

  a_r5_hold_in_row: assert property (@(posedge clk) disable iff (rst)
    !row_strobe_o |-> $stable(com_o));

  a_r2_unused_idle: assert property (@(posedge clk) disable iff (rst)
    !bias_fifth_o |-> (com_o[NUM_COM-1:ROWS_TALL] == '0));

  a_r9_bias_at_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_start_o |-> $stable(bias_fifth_o));
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.NUM_COM(NUM_COM), .ROWS_TALL(ROWS_TALL)) u_chk (
  .clk(clk), .rst(rst), .com_o(com_o), .row_strobe_o(row_strobe_o),
  .frame_start_o(frame_start_o), .bias_fifth_o(bias_fifth_o)
);

// File: tb/sim_lcd_com_scan.sv
module sim_lcd_com_scan;
  localparam int NC = 16;
  localparam int RL = 6;
  localparam int RS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic two_line = 1'b0, tall_font = 1'b0, wave_b = 1'b0;
  logic [NC-1:0] com;
  logic strobe, fstart, pol, bias5;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lcd_com_scan #(.NUM_COM(NC), .ROWS_TALL(11), .ROWS_SHORT(8),
                 .ROW_LONG(RL), .ROW_SHORT(RS)) u0 (
    .clk(clk), .rst(rst), .two_line_i(two_line), .tall_font_i(tall_font),
    .wave_b_i(wave_b), .com_o(com), .row_strobe_o(strobe),
    .frame_start_o(fstart), .polarity_o(pol), .bias_fifth_o(bias5));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare outputs against the position t clocks into a run of a fixed duty.
  // fidx_base offsets the frame count for the parity of the frame-flip scheme.
  task automatic check_pos(input int rows, input int t, input int fidx_base, input logic wb);
    int len, flen, row, cnt, fidx;
    len  = (rows == 16) ? RS : RL;
    flen = len * rows;
    fidx = fidx_base + t / flen;
    row  = (t % flen) / len;
    cnt  = t % len;
    check("R1 R3 R4 com", int'(com), 1 << row);
    check("R3 R5 strobe", int'(strobe), int'(cnt == 0));
    check("R6 frame start", int'(fstart), int'(t % flen == 0));
    if (wb) check("R8 polarity", int'(pol), fidx % 2);
    else    check("R7 polarity", int'(pol), int'(cnt >= len / 2));
    check("R2 bias", int'(bias5), int'(rows == 16));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset com", int'(com), 0);
    check("R10 reset strobe", int'(strobe), 0);
    check("R10 reset frame", int'(fstart), 0);
    check("R10 reset polarity", int'(pol), 0);
    check("R10 reset bias", int'(bias5), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Sweep every line/font/waveform combination.
    for (int cfg = 0; cfg < 8; cfg++) begin
      int rows, len;
      two_line  = cfg[0];
      tall_font = cfg[1];
      wave_b    = cfg[2];
      rows = two_line ? 16 : (tall_font ? 11 : 8);
      len  = (rows == 16) ? RS : RL;
      do_reset();
      for (int t = 0; t < 2 * rows * len + 5; t++) begin
        @(posedge clk);
        #1;
        check_pos(rows, t, 0, wave_b);
      end
    end

    // R9: switch from 8 rows to 16 rows in mid-frame, frame-flip polarity.
    two_line = 1'b0; tall_font = 1'b0; wave_b = 1'b1;
    do_reset();
    for (int t = 0; t < 8 * RL + 2 * 16 * RS; t++) begin
      @(posedge clk);
      #1;
      if (t < 8 * RL) check_pos(8, t, 0, 1'b1);
      else            check_pos(16, t - 8 * RL, 1, 1'b1);
      if (t == 10) two_line = 1'b1;
    end
    check("R9 ran into new duty", int'(bias5), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule